// File: doc/BRIEF.md
# PCM Serial Frame Receiver

This block takes 8-bit companded voice samples off a serial PCM bus and turns them into parallel bytes in the system clock domain. The bus carries three asynchronous inputs: a bit clock, a receive frame-sync, and serial data. All three are oversampled by a much faster system clock. The system clock must run at least eight times the highest bit rate. Each input passes through a two-flop synchronizer before any of its edges is detected.

A rising edge on frame-sync arms the receiver. The next eight falling edges of the bit clock each capture one data bit, most significant bit first. The finished byte is copied into a holding register and announced with a strobe one system cycle wide. The byte then stays on the output until the next word completes.

A separate counter watches for activity on the bit clock. If the bit clock stays at 1 or at 0 for longer than a programmable number of system cycles, the block raises a power-save request that covers both voice directions. Once the bit clock toggles again, the request drops. Any word that was in progress is thrown away, and reception restarts only at the next frame-sync rising edge.

Top module: `pcm_frame_rx`

## Requirements
- R1: Each word is built from the serial data sampled on eight consecutive bit-clock falling edges. The first sample becomes bit 7 of `byte_o` and the last becomes bit 0.
- R2: A word starts only after a frame-sync rising edge. Bit-clock falling edges with no new frame-sync rise after a completed word produce no strobe and leave `byte_o` unchanged.
- R3: `valid_o` is high for exactly one system cycle per completed word, and only after exactly eight bits.
- R4: `byte_o` changes only in the cycle where `valid_o` is high, and otherwise holds its value.
- R5: A frame-sync rising edge that arrives before eight bits are collected abandons the partial word without a strobe. Counting restarts from the MSB.
- R6: `psave_o` is 1 once the bit clock has stayed static, at either logic level, for more than `stall_limit` system cycles. It is 0 while the bit clock keeps toggling with gaps shorter than that.
- R7: After a stall, the first bit-clock edge clears `psave_o`. Bits that arrive before the next frame-sync rising edge are discarded, so a partial word is never delivered.
- R8: While `rst` is high and on its release, `valid_o` is 0, `byte_o` is 0 and `psave_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| fsync_i | input | 1 | Receive frame-sync, asynchronous |
| din_i | input | 1 | Serial PCM data, asynchronous |
| stall_limit | input | STALL_W | System-cycle count of bit-clock inactivity that raises power-save |
| byte_o | output | WORD_BITS | Last completed word |
| valid_o | output | 1 | One-cycle strobe when a new word is latched |
| psave_o | output | 1 | Power-save request for a stopped bit clock |

## Verification
All 256 byte values are sent as framed words, MSB first. This sweep separates a correct bit order and shift from a reversed, shortened or off-by-one capture. Three other patterns test framing on its own:
- eight unframed bits after a complete word, to test re-arming;
- a five-bit fragment cut off by a new frame-sync, to test abandoning a partial word;
- a word interrupted by a long stall and then resumed without a sync.

The bit clock is also held static at both logic levels, for one interval below the stall limit and one interval above it. This confirms that the power-save threshold applies to both levels and that the request clears when the clock resumes.

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx #(
  parameter int WORD_BITS = 8,
  parameter int STALL_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bclk_i,
  input  logic                 fsync_i,
  input  logic                 din_i,
  input  logic [STALL_W-1:0]   stall_limit,
  output logic [WORD_BITS-1:0] byte_o,
  output logic                 valid_o,
  output logic                 psave_o
);
  localparam int CNT_W = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [2:0]           bclk_p, fs_p;
  logic [1:0]           din_p;
  logic [STALL_W-1:0]   stall_cnt;
  logic [CNT_W-1:0]     bit_cnt;
  logic [WORD_BITS-1:0] shreg;
  logic                 armed;

  wire bclk_fall = bclk_p[2] & ~bclk_p[1];
  wire bclk_edge = bclk_p[2] ^ bclk_p[1];
  wire fs_rise   = ~fs_p[2] & fs_p[1];
  wire [WORD_BITS-1:0] next_sh = {shreg[WORD_BITS-2:0], din_p[1]};

  assign psave_o = stall_cnt > stall_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_p <= '0;
      fs_p   <= '0;
      din_p  <= '0;
    end else begin
      bclk_p <= {bclk_p[1:0], bclk_i};
      fs_p   <= {fs_p[1:0], fsync_i};
      din_p  <= {din_p[0], din_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bclk_edge) stall_cnt <= '0;
    else if (!(&stall_cnt)) stall_cnt <= stall_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fs_rise) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
      end else if (psave_o) begin
        armed   <= 1'b0;
      end else if (armed && bclk_fall) begin
        shreg   <= next_sh;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          byte_o  <= next_sh;
          valid_o <= 1'b1;
          armed   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_frame_rx_chk.sv
module pcm_frame_rx_chk #(
  parameter int WORD_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 valid_o,
  input logic [WORD_BITS-1:0] byte_o,
  input logic                 psave_o,
  input logic                 bclk_edge
);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_byte_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !$past(rst)) |-> $stable(byte_o));

  p_edge_clears_psave_r7: assert property (@(posedge clk) disable iff (rst)
    bclk_edge |=> !psave_o);

  p_no_strobe_in_psave_r6: assert property (@(posedge clk) disable iff (rst)
    psave_o |-> !valid_o);

  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (!valid_o && byte_o == '0 && !psave_o));
endmodule

bind pcm_frame_rx pcm_frame_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst(rst), .valid_o(valid_o), .byte_o(byte_o),
  .psave_o(psave_o), .bclk_edge(bclk_edge)
);

// File: tb/pcm_frame_rx_tb.sv
module pcm_frame_rx_tb;
  localparam int H = 8;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, fsync = 1'b0, din = 1'b0;
  logic [11:0] stall_limit = 12'(LIMIT);
  logic [7:0] byte_o;
  logic valid_o, psave_o;

  int checks = 0, errors = 0, nvalid = 0, dwidth = 0, dhold = 0;
  logic [7:0] prev_byte = '0;
  logic prev_valid = 1'b0;

  always #4 clk = ~clk;

  pcm_frame_rx u_dut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_i(fsync), .din_i(din),
    .stall_limit(stall_limit), .byte_o(byte_o), .valid_o(valid_o), .psave_o(psave_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) nvalid++;
      if (valid_o && prev_valid) dwidth++;
      if (!valid_o && byte_o != prev_byte) dhold++;
    end
    prev_valid = valid_o;
    prev_byte  = byte_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n, input bit sync);
    for (int i = 0; i < n; i++) begin
      bclk = 1'b1; din = v[7-i]; fsync = sync && (i == 0);
      idle(H);
      bclk = 1'b0;
      idle(H);
    end
    fsync = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    logic [7:0] b0;
    idle(5);
    rst = 1'b0;
    idle(1);
    chk(!valid_o && byte_o == 0 && !psave_o, "R8 reset state",
        {valid_o, psave_o, byte_o}, 0);

    for (int v = 0; v < 256; v++) begin
      n0 = nvalid;
      send_bits(8'(v), 8, 1'b1);
      chk(nvalid == n0 + 1, "R3 one strobe per word", nvalid - n0, 1);
      chk(byte_o == 8'(v), "R1 byte value MSB first", byte_o, v);
    end
    chk(dwidth == 0, "R3 strobe width one cycle", dwidth, 0);
    chk(dhold == 0, "R4 byte held between strobes", dhold, 0);

    n0 = nvalid; b0 = byte_o;
    send_bits(8'h5A, 8, 1'b0);
    chk(nvalid == n0, "R2 unframed bits ignored", nvalid - n0, 0);
    chk(byte_o == b0, "R2 byte unchanged", byte_o, b0);

    n0 = nvalid;
    send_bits(8'hA0, 5, 1'b1);
    send_bits(8'h3C, 8, 1'b1);
    chk(nvalid == n0 + 1, "R5 partial word abandoned", nvalid - n0, 1);
    chk(byte_o == 8'h3C, "R5 restarted word value", byte_o, 8'h3C);

    bclk = 1'b1; idle(20);
    chk(psave_o == 1'b0, "R6 no psave below limit (high)", psave_o, 0);
    idle(60);
    chk(psave_o == 1'b1, "R6 psave on static high", psave_o, 1);
    bclk = 1'b0; idle(6);
    chk(psave_o == 1'b0, "R7 psave clears on edge", psave_o, 0);
    idle(14);
    chk(psave_o == 1'b0, "R6 no psave below limit (low)", psave_o, 0);
    idle(60);
    chk(psave_o == 1'b1, "R6 psave on static low", psave_o, 1);

    n0 = nvalid; b0 = byte_o;
    send_bits(8'hF0, 4, 1'b1);
    idle(80);
    chk(psave_o == 1'b1, "R6 psave mid-word", psave_o, 1);
    send_bits(8'h0F, 4, 1'b0);
    chk(psave_o == 1'b0, "R7 psave cleared after resume", psave_o, 0);
    send_bits(8'hC3, 8, 1'b0);
    chk(nvalid == n0, "R7 data discarded after stall", nvalid - n0, 0);
    chk(byte_o == b0, "R7 byte unchanged after stall", byte_o, b0);
    send_bits(8'h96, 8, 1'b1);
    chk(nvalid == n0 + 1 && byte_o == 8'h96, "R7 resumes on frame sync", byte_o, 8'h96);

    rst = 1'b1; idle(2);
    chk(!valid_o && byte_o == 0 && !psave_o, "R8 reset clears byte",
        {valid_o, psave_o, byte_o}, 0);
    rst = 1'b0; idle(1);
    chk(dwidth == 0 && dhold == 0, "R4 hold and width over run", dwidth + dhold, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule